// File: doc/BRIEF.md
# Multidrop Serial Port with Address Wake-Up

This block is a full-duplex asynchronous serial port for a shared bus with one master node and several slave nodes. When the mode field selects the multidrop mode, every frame carries a ninth payload bit, the wake bit. A frame with wake bit 1 is an address frame and a frame with wake bit 0 is a data frame. The master sets the transmit-address control before writing a byte, which sends an address frame. It clears the control to send data frames. A slave keeps its receive-wake filter on. It then sees only address frames and compares each one in software. On a match it clears the filter and takes the data frames that follow. Slaves that do not match keep the filter on and never see that traffic.

Bytes to send come in through a valid/ready port. `tx_ready` is high only while the transmitter is idle. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. While a frame is on the line, `tx_ready` is low and a byte offered then is not taken. Received bytes leave through a valid/ready port. `rx_valid` stays high, with stable data, until the cycle in which `rx_ready` is high. The serial line cannot be held back, so a frame that arrives while a byte is still waiting replaces that byte and raises the overrun flag. In open-drain mode the serial output only pulls low and releases the line for high, so slaves can share one return wire.

Top module: `mdrop_uart`

## Requirements
- R1: The line idles high. A frame is one start bit (low), 8 data bits LSB first, an optional wake bit, and one stop bit (high). Each bit lasts CLK_DIV*OVS clock cycles. The first bit appears on the line in the cycle after the byte is taken.
- R2: The multidrop mode is on when cfg_mode is 2'b10 or 2'b11. In that mode the transmitted wake bit follows cfg_tx_addr (1 = address frame, 0 = data frame). With cfg_mode 2'b00 or 2'b01 the frame has no wake bit.
- R3: tx_busy is high from the cycle after the byte is taken until the stop bit ends. tx_ready equals !tx_busy. A byte offered while busy has no effect on the frame in flight.
- R4: With cfg_open_drain set, txd_o is 0 and txd_oe is 1 for a low bit. For a high bit txd_oe is 0. With cfg_open_drain clear, txd_oe is 1 and txd_o carries the line level.
- R5: In normal mode, a received frame with a high stop bit is delivered on rx_data, with rx_addr 0.
- R6: In multidrop mode with cfg_rx_wake set, received data frames (wake bit 0) are dropped: rx_valid stays low and rx_data is unchanged. Address frames are delivered with rx_addr 1.
- R7: In multidrop mode with cfg_rx_wake clear, data frames are delivered with rx_addr 0.
- R8: A stop bit sampled low drops the frame and sets rx_frame_err. The flag clears on a cycle with rx_ready high.
- R9: A frame delivered while rx_valid is high and rx_ready is low replaces rx_data and sets rx_overrun. The flag clears on a cycle with rx_ready high.
- R10: A low pulse shorter than half a bit is not taken as a start bit and delivers nothing.
- R11: rx_valid stays high until rx_ready is high. rx_irq equals rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Frame mode; bit 1 set selects multidrop |
| cfg_tx_addr | input | 1 | Wake bit value for transmitted frames |
| cfg_rx_wake | input | 1 | Receive filter: accept address frames only |
| cfg_open_drain | input | 1 | Serial output only pulls low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_busy | output | 1 | Frame on the line |
| txd_o | output | 1 | Serial output level |
| txd_oe | output | 1 | Serial output enable |
| rxd_i | input | 1 | Serial input |
| rx_data | output | 8 | Received byte |
| rx_addr | output | 1 | Wake bit of the held byte |
| rx_valid | output | 1 | Received byte is held |
| rx_ready | input | 1 | Consumer takes the byte and clears the flags |
| rx_irq | output | 1 | Receive interrupt |
| rx_overrun | output | 1 | A held byte was replaced |
| rx_frame_err | output | 1 | A frame had a low stop bit |

## Verification
The transmitter is driven with bytes in both normal and multidrop mode, with the address control both set and cleared, and with open drain on. Each clock is compared against a behavioural model, so a wrong bit order, a missing or misplaced wake bit, a bad bit length or a wrong drive mode all show up. The receiver gets address and data frames with the filter both on and off, so frames that should be dropped can be told apart from frames that should be delivered. It also gets a frame with a low stop bit, two frames back to back with no read between them, and a short glitch on the idle line, each of which has its own outcome at the ports.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;
endpackage

// File: rtl/mdu_baud.sv
module mdu_baud #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx #(
  parameter int DW       = 8,
  parameter int BIT_CLKS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          multi,
  input  logic          wake_bit,
  input  logic [DW-1:0] data,
  input  logic          valid,
  output logic          ready,
  output logic          busy,
  output logic          line
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(BIT_CLKS);
  localparam int IW = $clog2(FW + 1);

  logic [FW-1:0] frame_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q, last_q;
  logic          busy_q;
  logic          take;

  assign take  = valid && !busy_q;
  assign ready = !busy_q;
  assign busy  = busy_q;
  assign line  = busy_q ? frame_q[idx_q] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      busy_q  <= 1'b0;
    end else if (take) begin
      frame_q <= {1'b1, (multi ? wake_bit : 1'b1), data, 1'b0};
      last_q  <= multi ? IW'(FW - 1) : IW'(FW - 2);
      cnt_q   <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(BIT_CLKS - 1)) begin
        cnt_q <= '0;
        if (idx_q == last_q) busy_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line); // R1
  AST_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(frame_q)); // R3
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
  import mdu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          multi,
  output logic          done,
  output logic          bad_stop,
  output logic          frame_multi,
  output logic [DW-1:0] data,
  output logic          wb
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 2);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   sh_q;
  logic          armed_q, mq_q, done_q, bad_q;

  assign done        = done_q;
  assign bad_stop    = bad_q;
  assign frame_multi = mq_q;
  assign data        = mq_q ? sh_q[DW-1:0] : sh_q[DW:1];
  assign wb          = mq_q & sh_q[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      armed_q <= 1'b0; mq_q <= 1'b0; done_q <= 1'b0; bad_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      if (tick) begin
        case (st_q)
          RX_IDLE: begin
            if (rxd) armed_q <= 1'b1;
            else if (armed_q) begin
              st_q <= RX_START; cnt_q <= '0; armed_q <= 1'b0; mq_q <= multi;
            end
          end
          RX_START: begin
            if (cnt_q == HALF) begin
              cnt_q <= '0; idx_q <= '0;
              st_q  <= rxd ? RX_IDLE : RX_BITS;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_BITS: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {rxd, sh_q[DW:1]};
              if (idx_q == (mq_q ? IW'(DW) : IW'(DW - 1))) st_q <= RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0; st_q <= RX_IDLE;
              if (rxd) done_q <= 1'b1;
              else bad_q <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart #(
  parameter int CLK_DIV = 2,
  parameter int OVS     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_tx_addr,
  input  logic       cfg_rx_wake,
  input  logic       cfg_open_drain,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_busy,
  output logic       txd_o,
  output logic       txd_oe,
  input  logic       rxd_i,
  output logic [7:0] rx_data,
  output logic       rx_addr,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       rx_irq,
  output logic       rx_overrun,
  output logic       rx_frame_err
);
  localparam int DW       = 8;
  localparam int BIT_CLKS = CLK_DIV * OVS;

  logic          multi, tick, line;
  logic [1:0]    sync_q;
  logic          fr_done, fr_bad, fr_multi, fr_wb, deliver;
  logic [DW-1:0] fr_data;

  assign multi = (cfg_mode == 2'b10) || (cfg_mode == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else sync_q <= {sync_q[0], rxd_i};
  end

  mdu_baud #(.CLK_DIV(CLK_DIV)) u_baud (.clk(clk), .rst_n(rst_n), .tick(tick));

  mdu_tx #(.DW(DW), .BIT_CLKS(BIT_CLKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .multi(multi), .wake_bit(cfg_tx_addr),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready), .busy(tx_busy), .line(line)
  );

  mdu_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(sync_q[1]), .multi(multi),
    .done(fr_done), .bad_stop(fr_bad), .frame_multi(fr_multi), .data(fr_data), .wb(fr_wb)
  );

  assign txd_o  = cfg_open_drain ? 1'b0 : line;
  assign txd_oe = cfg_open_drain ? !line : 1'b1;

  assign deliver = fr_done && !(fr_multi && cfg_rx_wake && !fr_wb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_addr <= 1'b0; rx_valid <= 1'b0;
      rx_overrun <= 1'b0; rx_frame_err <= 1'b0;
    end else begin
      if (deliver) begin
        rx_data  <= fr_data;
        rx_addr  <= fr_wb;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (deliver && rx_valid && !rx_ready) rx_overrun <= 1'b1;
      else if (rx_ready) rx_overrun <= 1'b0;
      if (fr_bad) rx_frame_err <= 1'b1;
      else if (rx_ready) rx_frame_err <= 1'b0;
    end
  end

  assign rx_irq = rx_valid;

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open_drain && txd_oe) |-> !txd_o); // R4
  AST_WAKE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && $past(fr_multi && cfg_rx_wake)) |-> rx_addr); // R6
  AST_OVR_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_valid)); // R9
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid); // R11
endmodule

// File: tb/mdrop_uart_tb.sv
module mdrop_uart_tb;
  localparam int BIT = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cfg_tx_addr = 0, cfg_rx_wake = 0, cfg_open_drain = 0;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, rx_ready = 0, rxd_i = 1;
  logic tx_ready, tx_busy, txd_o, txd_oe, rx_addr, rx_valid, rx_irq, rx_overrun, rx_frame_err;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mdrop_uart u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural transmit model
  logic [10:0] mframe = '1;
  int mbit = 0, mcnt = 0, mlast = 0;
  bit mbusy = 0;
  always @(posedge clk) begin
    if (!rst_n) mbusy = 0;
    else if (!mbusy) begin
      if (tx_valid) begin
        mframe = {1'b1, (cfg_mode[1] ? cfg_tx_addr : 1'b1), tx_data, 1'b0};
        mlast = cfg_mode[1] ? 10 : 9;
        mbit = 0; mcnt = 0; mbusy = 1;
      end
    end else begin
      mcnt++;
      if (mcnt == BIT) begin
        mcnt = 0; mbit++;
        if (mbit > mlast) mbusy = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic el;
      el = mbusy ? mframe[mbit] : 1'b1;
      chk("R1 R2 txd_o", txd_o, cfg_open_drain ? 1'b0 : el);
      chk("R4 txd_oe", txd_oe, cfg_open_drain ? !el : 1'b1);
      chk("R3 tx_busy", tx_busy, mbusy);
      chk("R3 tx_ready", tx_ready, !mbusy);
      chk("R11 rx_irq", rx_irq, rx_valid);
    end
  end

  task automatic send_tx(input logic [7:0] d, input bit poke);
    @(negedge clk); tx_data = d; tx_valid = 1;
    @(negedge clk); tx_valid = 0;
    if (poke) begin
      repeat (50) @(negedge clk);
      tx_data = ~d; tx_valid = 1;
      repeat (3) @(negedge clk);
      tx_valid = 0;
    end
    while (tx_busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit has_wb, input bit wbv, input bit stop);
    @(negedge clk);
    rxd_i = 0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_i = d[i]; repeat (BIT) @(negedge clk); end
    if (has_wb) begin rxd_i = wbv; repeat (BIT) @(negedge clk); end
    rxd_i = stop; repeat (BIT) @(negedge clk);
    rxd_i = 1; repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset line high", txd_o, 1);
    chk("R3 reset not busy", tx_busy, 0);
    chk("R11 reset rx_valid", rx_valid, 0);
    chk("R9 reset overrun", rx_overrun, 0);
    chk("R8 reset frame err", rx_frame_err, 0);

    // transmit: normal, busy poke (R3), multidrop address/data (R2), open drain (R4)
    send_tx(8'hA5, 1);
    cfg_mode = 2'b10; cfg_tx_addr = 1;
    send_tx(8'h5A, 0);
    cfg_tx_addr = 0; cfg_mode = 2'b11;
    send_tx(8'h81, 1);
    cfg_open_drain = 1; cfg_tx_addr = 1;
    send_tx(8'h0F, 0);
    cfg_open_drain = 0;

    // R5 normal receive
    cfg_mode = 2'b00;
    send_rx(8'h96, 0, 0, 1);
    chk("R5 valid", rx_valid, 1); chk("R5 data", rx_data, 8'h96); chk("R5 addr", rx_addr, 0);
    repeat (20) @(negedge clk);
    chk("R11 held", rx_valid, 1);
    do_read();
    chk("R11 cleared by ready", rx_valid, 0);

    // R6 filter on
    cfg_mode = 2'b10; cfg_rx_wake = 1;
    send_rx(8'h11, 1, 0, 1);
    chk("R6 data frame dropped", rx_valid, 0);
    chk("R6 data unchanged", rx_data, 8'h96);
    send_rx(8'h42, 1, 1, 1);
    chk("R6 addr valid", rx_valid, 1); chk("R6 addr data", rx_data, 8'h42); chk("R6 rx_addr", rx_addr, 1);
    do_read();

    // R7 filter off
    cfg_rx_wake = 0;
    send_rx(8'h77, 1, 0, 1);
    chk("R7 valid", rx_valid, 1); chk("R7 data", rx_data, 8'h77); chk("R7 rx_addr", rx_addr, 0);
    do_read();
    cfg_rx_wake = 1;
    send_rx(8'h33, 1, 0, 1);
    chk("R6 dropped again", rx_valid, 0);

    // R8 framing error
    cfg_rx_wake = 0;
    send_rx(8'h55, 1, 0, 0);
    repeat (2 * BIT) @(negedge clk);
    chk("R8 frame err set", rx_frame_err, 1);
    chk("R8 no delivery", rx_valid, 0);
    do_read();
    chk("R8 frame err cleared", rx_frame_err, 0);

    // R9 overrun
    send_rx(8'h01, 1, 0, 1);
    send_rx(8'h02, 1, 0, 1);
    chk("R9 overrun set", rx_overrun, 1);
    chk("R9 data replaced", rx_data, 8'h02);
    chk("R11 still valid", rx_valid, 1);
    do_read();
    chk("R9 overrun cleared", rx_overrun, 0);
    chk("R11 valid cleared", rx_valid, 0);

    // R10 glitch rejection then recovery
    @(negedge clk); rxd_i = 0; repeat (6) @(negedge clk); rxd_i = 1;
    repeat (3 * BIT) @(negedge clk);
    chk("R10 glitch no valid", rx_valid, 0);
    chk("R10 glitch no error", rx_frame_err, 0);
    send_rx(8'hC3, 1, 1, 1);
    chk("R10 recovers data", rx_data, 8'hC3);
    chk("R10 recovers addr", rx_addr, 1);
    do_read();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule